// File: doc/BRIEF.md
# Gated 22 kHz Tone Generator

This block derives a 22 kHz square-wave tone from the system clock through a divider whose half-period count comes from two parameters, the clock frequency and the tone frequency. The tone path must first be armed. Arming needs the global operating enable to be high and, in addition, either a register bit or an external pin. The external pin is asynchronous and is resynchronised inside the block.

Once armed, the tone runs in one of two ways. A continuous-tone register bit starts it at once and keeps it running without a break. An asynchronous logic-level key input gates it for pulse-width data signalling: the tone begins half a tone period after the key rises, and it keeps running for about one more period after the key falls. Tone edges fall only on half-period boundaries, so the output has no short pulses.

A "tone active" flag spans the tone from its first rising edge to its last falling edge. Dropping the operating enable forces the whole path off at the next clock edge.

Top module: `tone22k_gen`

## Requirements
- R1: During and directly after synchronous reset, `tone_out` and `tone_active` are 0.
- R2: If the path is not armed (`sys_en` low, or both `path_en_reg` and the synchronised `path_en_pin` low), `tone_out` stays 0 whatever `cont_tone` and `key_in` do.
- R3: With the path armed through `path_en_reg`, setting `cont_tone` makes `tone_out` rise on the first clock edge. The tone then toggles every HALF clocks without a break for as long as `cont_tone` stays high, where HALF = floor(CLK_HZ/(2*TONE_HZ) + 0.5).
- R4: The tone period is 2*HALF clocks, and it lies within one clock of CLK_HZ/TONE_HZ.
- R5: With the path armed and `cont_tone` low, a rise of `key_in` makes `tone_out` rise on the (HALF+3)th clock edge after the change. That count is two synchroniser stages, one gate edge, and HALF clocks of lead.
- R6: A key pulse that ends before the lead time has passed produces no tone at all.
- R7: After the last request (key or continuous bit) is released, the tone keeps running and ends with a falling edge. Counted after a key fall, that edge comes between HALF+4 and 3*HALF+3 edges. Counted after a fall of the continuous bit, it comes between HALF+2 and 3*HALF+1 edges. After that edge `tone_out` stays 0.
- R8: If a request comes back during the trailing period, the tone carries on without a stop.
- R9: While `sys_en` is low, `tone_out` and `tone_active` are 0 from the next clock edge on.
- R10: Arming through `path_en_pin` goes through a two-stage synchroniser: with `cont_tone` already high, the tone rises on the third edge after the pin rises.
- R11: `tone_active` rises on the same edge as the first rising tone edge and falls on the same edge as the last falling tone edge. `tone_out` high always implies `tone_active` high.
- R12: While `tone_active` is high and the path stays armed, every high and low interval of `tone_out` is exactly HALF clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| path_en_reg | input | 1 | Tone path arm, register bit |
| path_en_pin | input | 1 | Tone path arm, asynchronous pin |
| cont_tone | input | 1 | Continuous tone request, register bit |
| key_in | input | 1 | Asynchronous data key for burst tone |
| sys_en | input | 1 | Global operating enable; low forces the path off |
| tone_out | output | 1 | 22 kHz square-wave tone |
| tone_active | output | 1 | High from the first to the last tone edge |

## Verification
Each result has its own latency, counted in clock edges after an input is driven between edges. A change of `cont_tone` or `sys_en` acts on the first edge. A change of `key_in` or `path_en_pin` acts on the third edge, after two synchroniser stages. A burst tone rises HALF edges after that. The bench drives every input on the falling clock edge and samples the outputs on the next falling edges, counting the rising edges in between, so every start latency is compared with an exact count. Tail lengths are compared with the window that the phase of the tone at release allows, and each interval between tone edges is checked against HALF.

// File: rtl/tone_pkg.sv
package tone_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_LEAD = 2'd1,
        GATE_RUN  = 2'd2,
        GATE_TAIL = 2'd3
    } gate_state_e;

    typedef struct packed {
        logic tone;
        logic active;
        logic run;
    } gate_out_s;

    // Rounded number of clocks in one half tone period.
    function automatic int unsigned half_count(input int unsigned clk_hz,
                                               input int unsigned tone_hz);
        return (clk_hz + tone_hz) / (2 * tone_hz);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tone_half_timer.sv
module tone_half_timer #(
    parameter int unsigned HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    import tone_pkg::*;

    localparam int unsigned CW = cnt_width(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tone_gate.sv
module tone_gate (
    input  logic                clk,
    input  logic                rst,
    input  logic                armed_i,
    input  logic                cont_i,
    input  logic                key_i,
    input  logic                tick_i,
    output tone_pkg::gate_out_s out_o
);
    import tone_pkg::*;

    gate_state_e state_q;
    logic        tone_q;
    logic        tail_seen_q;
    logic        want;

    assign want = key_i | cont_i;

    always_ff @(posedge clk) begin
        if (rst || !armed_i) begin
            state_q     <= GATE_IDLE;
            tone_q      <= 1'b0;
            tail_seen_q <= 1'b0;
        end else begin
            case (state_q)
                GATE_IDLE: begin
                    tail_seen_q <= 1'b0;
                    if (cont_i) begin
                        state_q <= GATE_RUN;
                        tone_q  <= 1'b1;
                    end else if (key_i) begin
                        state_q <= GATE_LEAD;
                    end
                end
                GATE_LEAD: begin
                    if (!want) begin
                        state_q <= GATE_IDLE;
                    end else if (tick_i) begin
                        state_q <= GATE_RUN;
                        tone_q  <= 1'b1;
                    end
                end
                GATE_RUN: begin
                    if (tick_i) begin
                        tone_q <= ~tone_q;
                    end
                    if (!want) begin
                        state_q     <= GATE_TAIL;
                        tail_seen_q <= 1'b0;
                    end
                end
                GATE_TAIL: begin
                    if (want) begin
                        state_q <= GATE_RUN;
                        if (tick_i) begin
                            tone_q <= ~tone_q;
                        end
                    end else if (tick_i) begin
                        if (tail_seen_q && tone_q) begin
                            tone_q  <= 1'b0;
                            state_q <= GATE_IDLE;
                        end else begin
                            tone_q      <= ~tone_q;
                            tail_seen_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= GATE_IDLE;
            endcase
        end
    end

    always_comb begin
        out_o.tone   = tone_q;
        out_o.active = (state_q == GATE_RUN) || (state_q == GATE_TAIL);
        out_o.run    = (state_q != GATE_IDLE);
    end

    // R2
    unarmed_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !armed_i |=> (state_q == GATE_IDLE) && !tone_q);

    // R12
    edge_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(armed_i) && ($past(state_q) != GATE_IDLE) && (tone_q != $past(tone_q)))
            |-> $past(tick_i));
endmodule

// File: rtl/tone22k_gen.sv
module tone22k_gen #(
    parameter int unsigned CLK_HZ  = 250_000_000,
    parameter int unsigned TONE_HZ = 22_000
) (
    input  logic clk,
    input  logic rst,
    input  logic path_en_reg,
    input  logic path_en_pin,
    input  logic cont_tone,
    input  logic key_in,
    input  logic sys_en,
    output logic tone_out,
    output logic tone_active
);
    import tone_pkg::*;

    localparam int unsigned HALF = half_count(CLK_HZ, TONE_HZ);

    logic [1:0] async_raw;
    logic [1:0] async_s;
    logic       pin_s;
    logic       key_s;
    logic       armed;
    logic       tick;
    gate_out_s  gate_out;

    assign async_raw = {path_en_pin, key_in};
    assign pin_s     = async_s[1];
    assign key_s     = async_s[0];

    tone_sync #(.W(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_raw),
        .q   (async_s)
    );

    assign armed = sys_en & (path_en_reg | pin_s);

    tone_half_timer #(.HALF(HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (gate_out.run),
        .tick (tick)
    );

    tone_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .armed_i (armed),
        .cont_i  (cont_tone),
        .key_i   (key_s),
        .tick_i  (tick),
        .out_o   (gate_out)
    );

    assign tone_out    = gate_out.tone;
    assign tone_active = gate_out.active;

    // R9
    standby_force_chk: assert property (@(posedge clk) disable iff (rst)
        !sys_en |=> (!tone_out && !tone_active));

    // R11
    active_span_chk: assert property (@(posedge clk) disable iff (rst)
        tone_out |-> tone_active);
endmodule

// File: tb/tone22k_gen_tb_top.sv
module tone22k_gen_tb_top;
    localparam int unsigned CLK_HZ  = 2_200_000;
    localparam int unsigned TONE_HZ = 22_000;

    function automatic int exp_half();
        return int'($floor(real'(CLK_HZ) / (2.0 * real'(TONE_HZ)) + 0.5));
    endfunction

    localparam int HALF = exp_half();

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic path_en_reg = 1'b0;
    logic path_en_pin = 1'b0;
    logic cont_tone   = 1'b0;
    logic key_in      = 1'b0;
    logic sys_en      = 1'b0;
    logic tone_out;
    logic tone_active;

    int total = 0;
    int bad   = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tone22k_gen #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .path_en_reg (path_en_reg),
        .path_en_pin (path_en_pin),
        .cont_tone   (cont_tone),
        .key_in      (key_in),
        .sys_en      (sys_en),
        .tone_out    (tone_out),
        .tone_active (tone_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Interval monitor: R11 and R12
    logic prev_tone = 1'b0;
    int   run_len   = 0;
    bit   run_ok    = 1'b0;
    always @(negedge clk) begin
        if (mon_en) begin
            if (tone_out && !tone_active) check(1'b0, "R11", tone_active, 1);
            if (tone_out != prev_tone) begin
                if (run_ok) check(run_len == HALF, "R12", run_len, HALF);
                run_len = 1;
                run_ok  = tone_active;
            end else begin
                run_len++;
            end
        end else begin
            run_ok = 1'b0;
        end
        prev_tone = tone_out;
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_silent(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tone_out || tone_active) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tone_out && n < 5 * HALF);
    endtask

    task automatic wait_end(output int m, output logic last);
        m = 0;
        last = tone_out;
        do begin
            last = tone_out;
            @(negedge clk);
            m++;
        end while (tone_active && m < 6 * HALF);
    endtask

    task automatic do_burst(input int hi_cyc);
        int n;
        int m;
        logic last;
        @(negedge clk);
        key_in = 1'b1;
        wait_rise(n);
        check(n == HALF + 3, "R5", n, HALF + 3);
        check(tone_active == 1'b1, "R11", tone_active, 1);
        idle(hi_cyc - n);
        key_in = 1'b0;
        wait_end(m, last);
        check(m >= HALF + 4 && m <= 3 * HALF + 3, "R7", m, HALF + 4);
        check(!tone_out && last, "R7", tone_out, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int m;
        int hi;
        int lo;
        int on_cnt;
        logic last;
        void'($urandom(32'd7741));

        // R1: reset state
        idle(4);
        check(!tone_out && !tone_active, "R1", tone_out, 0);
        rst = 1'b0;
        sys_en = 1'b1;
        @(negedge clk);
        check(!tone_out && !tone_active, "R1", tone_active, 0);
        mon_en = 1'b1;

        // R2: unarmed path
        cont_tone = 1'b1;
        expect_silent(4 * HALF, "R2");
        cont_tone = 1'b0;
        key_in = 1'b1;
        expect_silent(4 * HALF, "R2");
        key_in = 1'b0;
        idle(5);

        // R9: standby beats the arm and the request
        sys_en = 1'b0;
        path_en_reg = 1'b1;
        cont_tone = 1'b1;
        expect_silent(4 * HALF, "R9");
        cont_tone = 1'b0;
        sys_en = 1'b1;
        idle(5);

        // R3, R4: continuous tone
        cont_tone = 1'b1;
        wait_rise(n);
        check(n == 1, "R3", n, 1);
        hi = 0;
        while (tone_out) begin @(negedge clk); hi++; end
        lo = 0;
        while (!tone_out) begin @(negedge clk); lo++; end
        check(hi == HALF, "R3", hi, HALF);
        check(lo == HALF, "R3", lo, HALF);
        check(hi + lo == 2 * HALF, "R4", hi + lo, 2 * HALF);
        check((hi + lo) * int'(TONE_HZ) - int'(CLK_HZ) <= int'(TONE_HZ) &&
              int'(CLK_HZ) - (hi + lo) * int'(TONE_HZ) <= int'(TONE_HZ),
              "R4", hi + lo, int'(CLK_HZ / TONE_HZ));
        idle(3 * HALF + 7);
        cont_tone = 1'b0;
        wait_end(m, last);
        check(m >= HALF + 2 && m <= 3 * HALF + 1, "R7", m, HALF + 2);
        check(!tone_out && last, "R7", tone_out, 0);
        expect_silent(2 * HALF, "R7");

        // R9: standby during a running tone
        cont_tone = 1'b1;
        idle(HALF + 13);
        mon_en = 1'b0;
        sys_en = 1'b0;
        @(negedge clk);
        check(!tone_out && !tone_active, "R9", tone_out, 0);
        expect_silent(3 * HALF, "R9");
        sys_en = 1'b1;
        wait_rise(n);
        check(n == 1, "R3", n, 1);
        cont_tone = 1'b0;
        idle(4 * HALF);
        mon_en = 1'b1;

        // R10: arming through the pin
        path_en_reg = 1'b0;
        cont_tone = 1'b1;
        idle(3);
        check(!tone_out, "R10", tone_out, 0);
        path_en_pin = 1'b1;
        wait_rise(n);
        check(n == 3, "R10", n, 3);
        cont_tone = 1'b0;
        idle(4 * HALF);
        path_en_pin = 1'b0;
        path_en_reg = 1'b1;
        idle(5);

        // R6: key pulse shorter than the lead
        key_in = 1'b1;
        idle(10);
        key_in = 1'b0;
        expect_silent(4 * HALF, "R6");

        // R5, R7: directed burst, then random bursts
        do_burst(3 * HALF);
        idle(10);
        for (int k = 0; k < 6; k++) begin
            do_burst(3 * HALF + int'($urandom_range(5 * HALF)));
            idle(int'($urandom_range(80, 20)));
        end

        // R8: request returns during the trailing period
        @(negedge clk);
        key_in = 1'b1;
        wait_rise(n);
        check(n == HALF + 3, "R5", n, HALF + 3);
        idle(2 * HALF);
        key_in = 1'b0;
        on_cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tone_active) on_cnt++;
        end
        key_in = 1'b1;
        for (int i = 0; i < 2 * HALF; i++) begin
            @(negedge clk);
            if (tone_active) on_cnt++;
        end
        check(on_cnt == 10 + 2 * HALF, "R8", on_cnt, 10 + 2 * HALF);
        key_in = 1'b0;
        wait_end(m, last);
        check(m >= HALF + 4 && m <= 3 * HALF + 3, "R7", m, HALF + 4);
        idle(10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule